// File: doc/BRIEF.md
# Chainable Serial Peripheral Slave Shift Stage

This block is the receiving end of a four-wire serial peripheral link. A controller drives the serial clock, the data-in line and an active-low select. The block samples all three with the system clock and answers on a data-out line that it drives only while selected. While selected it swaps words with the controller in both directions at once, most significant bit first. Each completed word is handed to the core on a parallel output with a one-cycle strobe. The reply for each word comes from a parallel input.

Several of these stages can share one select line in a ring, each data-out feeding the next stage's data-in. With chaining turned on, a stage sends its own reply word once. From then on it sends back whatever it received, one word length later. The string of stages then acts as a single long shift register until the select is released. Clock polarity and phase come from a two-bit mode number. The word length can be 8, 12 or 16 bits.

Top module: `spi_chain_slave`

## Requirements
- R1: `spiMode[1]` is the serial clock idle level and `spiMode[0]` the phase; the leading edge is the first transition away from the idle level.
- R2: Words travel most significant bit first; each sampled data-in bit becomes the new least significant bit, so `rxWord` holds the bits in arrival order.
- R3: With phase 0 the reply bit is valid before each leading edge and data-in is taken on the leading edge; with phase 1 the reply bit changes after the leading edge and data-in is taken on the trailing edge.
- R4: While the synchronised select is high, clock and data-in toggles have no effect and `misoOe` is 0.
- R5: `wlSel` sets the word length: 00 gives 8 bits, 01 gives 12 bits, 10 or 11 gives 16 bits; `rxWord` is zero above the word length.
- R6: `rxValid` is a one-cycle pulse, once for every completed word, and `rxWord` only changes together with it.
- R7: `txWord` is copied into the reply shift register when the select falls and, with `chainEn` = 0, again at every word boundary.
- R8: With `chainEn` = 1, every word sent after the first is an exact copy of the word received just before it, for as long as the select stays low.
- R9: A select release in the middle of a word drops the partial word with no strobe, and the next selection starts again at bit 0 of a new word.
- R10: Each pin passes two synchroniser flops, so `misoOe` follows the select pin, inverted, two system clocks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| spiMode | input | 2 | Mode number: bit 1 clock idle level, bit 0 phase |
| wlSel | input | 2 | Word length select |
| chainEn | input | 1 | 1 = forward received words after the first reply |
| txWord | input | 16 | Reply word, right-aligned |
| sclkPin | input | 1 | Serial clock from the controller |
| mosiPin | input | 1 | Serial data from the controller |
| ssNPin | input | 1 | Active-low select |
| misoOut | output | 1 | Serial reply data |
| misoOe | output | 1 | Output enable for the reply pad |
| rxWord | output | 16 | Last completed received word, zero-extended |
| rxValid | output | 1 | One-cycle strobe for a completed word |

## Verification
The checker watches, on every cycle, that the output enable tracks the select pin with its two-cycle delay. It also checks that the strobe never lasts two cycles and only comes while the block was selected, that the received word is zero above the chosen length, and that the word holds still between strobes. What no single-cycle property can show is the bit order on the reply line under each of the four modes. The same goes for the reload of replies at word boundaries versus forwarding in chain mode, and for dropping a partial word. These the bench shows by playing the controller against a behavioural model of the expected reply and received words.

// File: rtl/spi_chain_pkg.sv
package spi_chain_pkg;
  localparam int MAX_W = 16;
  localparam int CNT_W = $clog2(MAX_W + 1);
  localparam int IDX_W = $clog2(MAX_W);
  localparam int LEN_SHORT = 8;
  localparam int LEN_MID = 12;

  typedef struct packed {
    logic sample;
    logic shift;
    logic load;
    logic wordDone;
  } dpCtrl_t;

  function automatic logic [CNT_W-1:0] wordLenOf(input logic [1:0] sel);
    case (sel)
      2'b00:   return CNT_W'(LEN_SHORT);
      2'b01:   return CNT_W'(LEN_MID);
      default: return CNT_W'(MAX_W);
    endcase
  endfunction
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int N_PINS = 3,
  parameter int STAGES = 2,
  parameter logic [N_PINS-1:0] RESET_VAL = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [N_PINS-1:0] pinIn,
  output logic [N_PINS-1:0] pinSync,
  output logic [N_PINS-1:0] pinPrev
);
  for (genvar g = 0; g < N_PINS; g++) begin : g_pin
    logic [STAGES-1:0] stg;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stg <= {STAGES{RESET_VAL[g]}};
      else       stg <= {stg[STAGES-2:0], pinIn[g]};
    end
    assign pinSync[g] = stg[STAGES-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinPrev <= RESET_VAL;
    else       pinPrev <= pinSync;
  end
endmodule

// File: rtl/spi_chain_ctrl.sv
module spi_chain_ctrl
  import spi_chain_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclkNow,
  input  logic       sclkPrev,
  input  logic       ssNow,
  input  logic       ssPrev,
  input  logic [1:0] spiMode,
  input  logic [1:0] wlSel,
  input  logic       chainEn,
  output dpCtrl_t    ctl,
  output logic       selected
);
  logic             riseEdge, fallEdge, leadEdge, trailEdge;
  logic             sampleEdge, driveEdge, ssFall;
  logic [CNT_W-1:0] wordLen, bitCnt, bitCntNxt;
  logic             pending, pendingNxt, atBoundary, atBoundaryNxt;

  assign riseEdge   = sclkNow & ~sclkPrev;
  assign fallEdge   = ~sclkNow & sclkPrev;
  assign leadEdge   = spiMode[1] ? fallEdge : riseEdge;
  assign trailEdge  = spiMode[1] ? riseEdge : fallEdge;
  assign sampleEdge = spiMode[0] ? trailEdge : leadEdge;
  assign driveEdge  = spiMode[0] ? leadEdge : trailEdge;
  assign selected   = ~ssNow;
  assign ssFall     = ssPrev & ~ssNow;
  assign wordLen    = wordLenOf(wlSel);

  always_comb begin
    ctl           = '0;
    bitCntNxt     = bitCnt;
    pendingNxt    = pending;
    atBoundaryNxt = atBoundary;
    if (ssFall) begin
      ctl.load      = 1'b1;
      bitCntNxt     = '0;
      pendingNxt    = 1'b0;
      atBoundaryNxt = 1'b0;
    end else if (!selected) begin
      bitCntNxt     = '0;
      pendingNxt    = 1'b0;
      atBoundaryNxt = 1'b0;
    end else if (sampleEdge) begin
      ctl.sample = 1'b1;
      pendingNxt = 1'b1;
      if (bitCnt + CNT_W'(1) == wordLen) begin
        ctl.wordDone  = 1'b1;
        bitCntNxt     = '0;
        atBoundaryNxt = 1'b1;
      end else begin
        bitCntNxt = bitCnt + CNT_W'(1);
      end
    end else if (driveEdge && pending) begin
      pendingNxt    = 1'b0;
      atBoundaryNxt = 1'b0;
      if (atBoundary && !chainEn) ctl.load  = 1'b1;
      else                        ctl.shift = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt     <= '0;
      pending    <= 1'b0;
      atBoundary <= 1'b0;
    end else begin
      bitCnt     <= bitCntNxt;
      pending    <= pendingNxt;
      atBoundary <= atBoundaryNxt;
    end
  end
endmodule

// File: rtl/spi_chain_dp.sv
module spi_chain_dp
  import spi_chain_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  dpCtrl_t          ctl,
  input  logic             mosiBit,
  input  logic [1:0]       wlSel,
  input  logic [MAX_W-1:0] txWord,
  output logic             misoBit,
  output logic [MAX_W-1:0] rxWord,
  output logic             rxValid
);
  logic [MAX_W-1:0] shiftReg, rxAcc, lenMask, rxNext;
  logic             heldBit;
  logic [CNT_W-1:0] wordLen;
  logic [IDX_W-1:0] topIdx;

  assign wordLen = wordLenOf(wlSel);
  assign topIdx  = IDX_W'(wordLen - CNT_W'(1));
  assign misoBit = shiftReg[topIdx];
  assign rxNext  = {rxAcc[MAX_W-2:0], mosiBit};

  always_comb begin
    for (int i = 0; i < MAX_W; i++) lenMask[i] = (i < int'(wordLen));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      heldBit  <= 1'b0;
      rxAcc    <= '0;
      rxWord   <= '0;
      rxValid  <= 1'b0;
    end else begin
      rxValid <= ctl.wordDone;
      if (ctl.sample) begin
        heldBit <= mosiBit;
        rxAcc   <= rxNext;
      end
      if (ctl.wordDone) rxWord <= rxNext & lenMask;
      if (ctl.load)       shiftReg <= txWord;
      else if (ctl.shift) shiftReg <= {shiftReg[MAX_W-2:0], heldBit};
    end
  end
endmodule

// File: rtl/spi_chain_slave.sv
module spi_chain_slave
  import spi_chain_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       spiMode,
  input  logic [1:0]       wlSel,
  input  logic             chainEn,
  input  logic [MAX_W-1:0] txWord,
  input  logic             sclkPin,
  input  logic             mosiPin,
  input  logic             ssNPin,
  output logic             misoOut,
  output logic             misoOe,
  output logic [MAX_W-1:0] rxWord,
  output logic             rxValid
);
  localparam int N_PINS = 3;
  localparam logic [N_PINS-1:0] PIN_RST = 3'b100;

  logic [N_PINS-1:0] pinSync, pinPrev;
  dpCtrl_t           ctl;
  logic              selected;

  spi_pin_sync #(.N_PINS(N_PINS), .STAGES(2), .RESET_VAL(PIN_RST)) sync_i (
    .clk(clk), .rstN(rstN), .pinIn({ssNPin, mosiPin, sclkPin}),
    .pinSync(pinSync), .pinPrev(pinPrev));

  spi_chain_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .sclkNow(pinSync[0]), .sclkPrev(pinPrev[0]),
    .ssNow(pinSync[2]), .ssPrev(pinPrev[2]), .spiMode(spiMode),
    .wlSel(wlSel), .chainEn(chainEn), .ctl(ctl), .selected(selected));

  spi_chain_dp dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .mosiBit(pinSync[1]), .wlSel(wlSel),
    .txWord(txWord), .misoBit(misoOut), .rxWord(rxWord), .rxValid(rxValid));

  assign misoOe = selected;
endmodule

// File: rtl/spi_chain_slave_chk.sv
module spi_chain_slave_chk
  import spi_chain_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       wlSel,
  input logic             ssNPin,
  input logic             misoOe,
  input logic [MAX_W-1:0] rxWord,
  input logic             rxValid
);
  logic [1:0] upCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              upCnt <= '0;
    else if (upCnt != 2'd3) upCnt <= upCnt + 2'd1;
  end

  // R4 and R10: enable follows the select pin two clocks later
  p_oe_tracks_ss_r10: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt >= 2'd2) |-> (misoOe == !$past(ssNPin, 2)));

  p_strobe_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  p_word_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !rxValid |-> $stable(rxWord));

  // R9: no strobe for a word unless the block was selected
  p_strobe_selected_r9: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> $past(misoOe));

  p_zero_ext_r5: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> ((rxWord >> wordLenOf(wlSel)) == '0));
endmodule

bind spi_chain_slave spi_chain_slave_chk chk_i (
  .clk(clk), .rstN(rstN), .wlSel(wlSel), .ssNPin(ssNPin),
  .misoOe(misoOe), .rxWord(rxWord), .rxValid(rxValid));

// File: tb/spi_chain_slave_tb_top.sv
module spi_chain_slave_tb_top;
  localparam int HALF = 6;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  spiMode = 2'b00;
  logic [1:0]  wlSel = 2'b00;
  logic        chainEn = 1'b0;
  logic [15:0] txWord = '0;
  logic        sclkPin = 1'b0;
  logic        mosiPin = 1'b0;
  logic        ssNPin = 1'b1;
  logic        misoOut, misoOe, rxValid;
  logic [15:0] rxWord;

  int nChecks = 0;
  int nBad = 0;
  int warm = 0;
  logic h0 = 1'b1, h1 = 1'b1;
  logic [15:0] expQ[$];

  always #10 clk = ~clk;

  spi_chain_slave dut_i (
    .clk(clk), .rstN(rstN), .spiMode(spiMode), .wlSel(wlSel), .chainEn(chainEn),
    .txWord(txWord), .sclkPin(sclkPin), .mosiPin(mosiPin), .ssNPin(ssNPin),
    .misoOut(misoOut), .misoOe(misoOe), .rxWord(rxWord), .rxValid(rxValid));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // reference pipeline of the select pin (two flops) and per-clock compare
  always @(posedge clk) begin
    h1 <= h0;
    h0 <= ssNPin;
    if (rstN) warm <= warm + 1;
  end

  always @(negedge clk) begin
    if (rstN && warm >= 2)
      chk(misoOe == !h1, "R4/R10 output enable", int'(misoOe), int'(!h1));
    if (rstN && rxValid) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R9 unexpected strobe", int'(rxWord), 0);
      end else begin
        logic [15:0] e;
        e = expQ.pop_front();
        chk(rxWord == e, "R2/R5/R6 received word", int'(rxWord), int'(e));
      end
    end
  end

  function automatic int lenOf(input logic [1:0] wl);
    return (wl == 2'b00) ? 8 : (wl == 2'b01) ? 12 : 16;
  endfunction

  // controller model: nBits may stop short of a full word (R9)
  task automatic xfer(input logic [1:0] mode, input logic [1:0] wl, input bit chain,
                      input int nBits, input logic [15:0] mw[4], input logic [15:0] tw[4]);
    int len;
    len = lenOf(wl);
    spiMode = mode; wlSel = wl; chainEn = chain;
    sclkPin = mode[1]; txWord = tw[0];
    tick(HALF);
    ssNPin = 1'b0;
    tick(HALF);
    for (int b = 0; b < nBits; b++) begin
      int w, i;
      logic expBit, mbit;
      w = b / len;
      i = len - 1 - (b % len);
      expBit = (!chain || w == 0) ? tw[w][i] : mw[w-1][i];
      mbit = mw[w][i];
      if (i == 0) expQ.push_back(mw[w] & 16'((32'h1 << len) - 1));
      if (!mode[0]) begin
        mosiPin = mbit;
        tick(HALF - 1);
        @(negedge clk);
        chk(misoOut == expBit, chain ? "R8 forwarded bit (phase 0)" : "R3/R7 reply bit (phase 0)",
            int'(misoOut), int'(expBit));
        @(posedge clk); #1;
        sclkPin = ~mode[1];
        tick(HALF);
        sclkPin = mode[1];
      end else begin
        sclkPin = ~mode[1];
        mosiPin = mbit;
        tick(HALF - 1);
        @(negedge clk);
        chk(misoOut == expBit, chain ? "R8 forwarded bit (phase 1)" : "R3/R7 reply bit (phase 1)",
            int'(misoOut), int'(expBit));
        @(posedge clk); #1;
        sclkPin = mode[1];
        tick(HALF);
      end
      if ((b % len) == 0 && w < 3) txWord = tw[w+1];
    end
    tick(HALF);
    ssNPin = 1'b1;
    tick(3 * HALF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    report();
  end

  initial begin
    tick(5);
    rstN = 1'b1;
    tick(3);
    @(negedge clk);
    chk(misoOe == 1'b0, "R4 reset enable", int'(misoOe), 0);
    chk(rxValid == 1'b0, "R6 reset strobe", int'(rxValid), 0);
    chk(rxWord == 16'h0, "R6 reset word", int'(rxWord), 0);
    @(posedge clk); #1;

    // R1 R2 R3 R7: mode 0, 8 bits, reload per word
    xfer(2'b00, 2'b00, 1'b0, 16, '{16'h00A5, 16'h003C, 0, 0}, '{16'h00C3, 16'h0081, 0, 0});
    // mode 3, 16 bits
    xfer(2'b11, 2'b10, 1'b0, 32, '{16'hBEEF, 16'h1234, 0, 0}, '{16'h8001, 16'h5AA5, 0, 0});
    // R5: mode 1, 12 bits, three words
    xfer(2'b01, 2'b01, 1'b0, 36, '{16'h0ABC, 16'h0F0F, 16'h0801, 0},
         '{16'h0963, 16'h0E1D, 16'h0777, 0});
    // R8: chain forwarding, mode 2, 8 bits
    xfer(2'b10, 2'b00, 1'b1, 24, '{16'h0096, 16'h004B, 16'h00F0, 0},
         '{16'h0011, 16'h00FF, 16'h00FF, 0});
    // R8: chain, mode 1, 16 bits
    xfer(2'b01, 2'b11, 1'b1, 32, '{16'hC0DE, 16'h7E57, 0, 0}, '{16'h0F1E, 16'hFFFF, 0, 0});
    // R9: partial word, no strobe
    xfer(2'b00, 2'b00, 1'b0, 5, '{16'h00FF, 0, 0, 0}, '{16'h0055, 0, 0, 0});
    // R4: activity while deselected is ignored
    for (int k = 0; k < 20; k++) begin
      sclkPin = ~sclkPin;
      mosiPin = k[1];
      tick(HALF);
    end
    sclkPin = 1'b0;
    tick(HALF);
    chk(expQ.size() == 0, "R4 no strobe while deselected", expQ.size(), 0);
    // R9: fresh start after the abort and the idle activity
    xfer(2'b00, 2'b00, 1'b0, 8, '{16'h0069, 0, 0, 0}, '{16'h00B2, 0, 0, 0});
    // R8 with 12 bits, mode 2
    xfer(2'b10, 2'b01, 1'b1, 36, '{16'h0A5A, 16'h0123, 16'h0FED, 0},
         '{16'h0C0C, 16'h0000, 16'h0000, 0});
    tick(10);
    chk(expQ.size() == 0, "R6 strobe count", expQ.size(), 0);
    report();
  end
endmodule